// File: doc/BRIEF.md
# Audio Playback Sample FIFO

This block sits between a bus master or DMA engine and a DAC datapath. Software and DMA place playback samples through a 32-bit register-write port. Each accepted word is converted into one fixed-width sample and held in an internal FIFO. On every `sample_tick` the block hands one output frame to the DAC. A frame takes one stored entry in mono mode, where that entry goes to both channels. In stereo mode a frame takes two entries, the first for the left channel and the second for the right.

A DMA request level is driven from the FIFO's free space, with hysteresis. The request goes high when free space rises above a programmable threshold. It goes low when free space falls below a programmable low-water level. A control register holds the following:
- the input width (16 or 24 bits),
- how a 16-bit sample is widened (zero pad or MSB repeat),
- mono or stereo,
- what is played when the FIFO cannot supply a frame (zeros or the previous frame),
- a sample-rate code that the block only exports.

A status register reports free space, an empty flag and sticky underrun and overrun flags. A writable counter tracks consumed entries.

Register word addresses (`bus_addr`):

| Address | Register |
|---|---|
| 0 | control |
| 1 | status |
| 2 | sample data |
| 3 | consumed-entry counter |

Control bits:

| Bits | Field |
|---|---|
| [0] | flush |
| [1] | request enable |
| [2] | 24-bit input |
| [3] | MSB repeat |
| [4] | mono |
| [5] | hold last on underrun |
| [7:6] | stop code |
| [13:8] | threshold |
| [18:16] | rate code |

Status bits:

| Bits | Field |
|---|---|
| [15:0] | free entries |
| [16] | empty |
| [17] | underrun |
| [18] | overrun |

Top module: `dac_txfifo`

## Requirements
- R1: After reset the status register reads free=DEPTH (32), empty=1, underrun=0 and overrun=0. The control register reads 0, `dma_req` is 0, and both DAC outputs are 0.
- R2: A write to address 2 stores one entry and lowers free space by one. A write to address 2 while the FIFO is full is dropped, leaves free space at 0, and sets the sticky overrun flag (status bit 18). Writing 1 to bit 18 clears that flag.
- R3: Writing control with bit 0 set makes bit 0 read 1 on the next cycle. One cycle after that, the FIFO is empty (free=DEPTH) and bit 0 reads 0.
- R4: With requests enabled, the internal request state sets when free > threshold (bits [13:8]) and clears when free < 4*(stop code+1), where the stop code is bits [7:6] and code 3 gives 16. Between the two levels the state holds. Each change appears on `dma_req` one cycle after the free count changes.
- R5: Clearing the enable bit (control bit 1) drops `dma_req` in the cycle after the write, without changing the stored entries.
- R6: In 16-bit mode with MSB repeat clear, an output sample is `{d[15:0], 8'h00}`.
- R7: In 16-bit mode with MSB repeat set, an output sample is `{d[15:0], d[15:8]}`.
- R8: In 24-bit mode, an output sample is `d[31:8]`.
- R9: In mono mode a tick consumes one entry and drives it on both channels. In stereo mode a tick consumes two entries: the older one goes to the left channel and the newer one to the right.
- R10: A tick that finds fewer entries than a frame needs consumes nothing and sets the sticky underrun flag (status bit 17, cleared by writing 1). With the hold bit clear, the outputs become 0. With the hold bit set, the outputs keep the previous frame. `dac_valid` pulses in the cycle after every tick.
- R11: `rate_code` equals control bits [18:16].
- R12: The counter at address 3 can be written. It then adds the number of entries consumed by each successful tick (1 in mono, 2 in stereo).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| sample_tick | input | 1 | One-cycle pulse per output frame |
| dma_req | output | 1 | DMA request level |
| rate_code | output | 3 | Exported sample-rate code |
| dac_valid | output | 1 | Pulses when a new frame is on the outputs |
| dac_left | output | OUT_W | Left channel sample |
| dac_right | output | OUT_W | Right channel sample |

## Verification
The properties assume the following about the inputs:
- `sample_tick` is a single-cycle pulse.
- Bus strobes are known values after reset.
- Status clears are written as deliberate one-bits.

The properties also assume that no data write lands in the cycle that a flush is executing. The directed stimulus keeps to these limits in three ways:
- It drives every bus write and every tick as an isolated one-cycle pulse at the falling edge.
- It inserts an idle cycle after each flush before writing samples.
- It never issues a tick in the same cycle as a write.

// File: rtl/dac_txfifo.sv
module dac_txfifo #(
  parameter int DEPTH = 32,
  parameter int OUT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             sample_tick,
  output logic             dma_req,
  output logic [2:0]       rate_code,
  output logic             dac_valid,
  output logic [OUT_W-1:0] dac_left,
  output logic [OUT_W-1:0] dac_right
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int PADW = OUT_W - 16;

  logic             flush_q, dma_en, wide, msb_rep, mono, hold_last, req_q, urun, orun;
  logic [1:0]       stop_code;
  logic [5:0]       thresh;
  logic [31:0]      scnt;
  logic [OUT_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic [OUT_W-1:0] fmt;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire ctrl_wr = bus_wr && bus_addr == 2'd0;
  wire stat_wr = bus_wr && bus_addr == 2'd1;
  wire data_wr = bus_wr && bus_addr == 2'd2 && !flush_q;
  wire cnt_wr  = bus_wr && bus_addr == 2'd3;

  wire [CW-1:0] free  = CW'(DEPTH) - count;
  wire          full  = count == CW'(DEPTH);
  wire          empty = count == '0;
  wire [CW-1:0] need  = mono ? CW'(1) : CW'(2);
  wire          pop   = sample_tick && !flush_q && count >= need;
  wire          push  = data_wr && !full;
  wire          drop  = data_wr && full;
  wire [CW-1:0] n_pop = pop ? need : '0;
  wire [AW-1:0] rd_nx = inc(rd_ptr);

  assign dma_req   = dma_en && req_q;
  assign rate_code = rate_q;

  logic [2:0] rate_q;

  always_comb begin
    if (wide)         fmt = bus_wdata[31 -: OUT_W];
    else if (msb_rep) fmt = {bus_wdata[15:0], bus_wdata[15 -: PADW]};
    else              fmt = {bus_wdata[15:0], {PADW{1'b0}}};
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {13'b0, rate_q, 2'b0, thresh, stop_code, hold_last,
                            mono, msb_rep, wide, dma_en, flush_q};
      2'd1:    bus_rdata = {13'b0, orun, urun, empty, 16'(free)};
      2'd3:    bus_rdata = scnt;
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) if (push) mem[wr_ptr] <= fmt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {flush_q, dma_en, wide, msb_rep, mono, hold_last} <= '0;
      stop_code <= '0;
      thresh    <= '0;
      rate_q    <= '0;
    end else if (ctrl_wr) begin
      flush_q   <= bus_wdata[0];
      dma_en    <= bus_wdata[1];
      wide      <= bus_wdata[2];
      msb_rep   <= bus_wdata[3];
      mono      <= bus_wdata[4];
      hold_last <= bus_wdata[5];
      stop_code <= bus_wdata[7:6];
      thresh    <= bus_wdata[13:8];
      rate_q    <= bus_wdata[18:16];
    end else if (flush_q) begin
      flush_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush_q) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= inc(wr_ptr);
      if (pop)  rd_ptr <= mono ? rd_nx : inc(rd_nx);
      count <= count + CW'(push) - n_pop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else if (int'(free) > int'(thresh)) req_q <= 1'b1;
    else if (int'(free) < int'(stop_code) * 4 + 4) req_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      urun <= 1'b0;
      orun <= 1'b0;
    end else begin
      if (sample_tick && !pop)             urun <= 1'b1;
      else if (stat_wr && bus_wdata[17])   urun <= 1'b0;
      if (drop)                            orun <= 1'b1;
      else if (stat_wr && bus_wdata[18])   orun <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      scnt <= '0;
    else if (cnt_wr) scnt <= bus_wdata;
    else if (pop)    scnt <= scnt + 32'(need);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_valid <= 1'b0;
      dac_left  <= '0;
      dac_right <= '0;
    end else begin
      dac_valid <= sample_tick;
      if (pop) begin
        dac_left  <= mem[rd_ptr];
        dac_right <= mono ? mem[rd_ptr] : mem[rd_nx];
      end else if (sample_tick && !hold_last) begin
        dac_left  <= '0;
        dac_right <= '0;
      end
    end
  end
endmodule

// File: rtl/dac_txfifo_chk.sv
module dac_txfifo_chk #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [1:0]    bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          sample_tick,
  input logic [CW-1:0] count,
  input logic          flush_q,
  input logic          dma_en,
  input logic          dma_req,
  input logic          urun,
  input logic          dac_valid
);
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count) == DEPTH && bus_wr && bus_addr == 2'd2 && !sample_tick && !flush_q)
      |=> int'(count) == DEPTH);

  p_flush_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_q && !(bus_wr && bus_addr == 2'd0)) |=> (count == '0 && !flush_q));

  p_req_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !dma_req);

  p_urun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (urun && !(bus_wr && bus_addr == 2'd1 && bus_wdata[17])) |=> urun);

  p_valid_follows_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> dac_valid);
endmodule

bind dac_txfifo dac_txfifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .sample_tick(sample_tick), .count(count),
  .flush_q(flush_q), .dma_en(dma_en), .dma_req(dma_req), .urun(urun),
  .dac_valid(dac_valid)
);

// File: tb/sim_dac_txfifo.sv
`timescale 1ns/1ps
module sim_dac_txfifo;
  logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, sample_tick = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        dma_req, dac_valid;
  logic [2:0]  rate_code;
  logic [23:0] dac_left, dac_right;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  dac_txfifo u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sample_tick(sample_tick),
    .dma_req(dma_req), .rate_code(rate_code), .dac_valid(dac_valid),
    .dac_left(dac_left), .dac_right(dac_right));

  function automatic logic [31:0] cfg(bit en, bit wide, bit msb, bit mono, bit hold,
                                      logic [1:0] stop, logic [5:0] thr, logic [2:0] rate);
    return {13'b0, rate, 2'b0, thr, stop, hold, mono, msb, wide, en, 1'b0};
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    bus_addr = a; #0.1; d = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk); sample_tick = 1'b1;
    @(negedge clk); sample_tick = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(logic [31:0] c);
    wr(2'd0, c | 32'h1);
    idle(1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd1, d); chk("R1 status", d, 32'h0001_0020);
    rd(2'd0, d); chk("R1 ctrl", d, 0);
    chk("R1 req", dma_req, 0);
    chk("R1 dac", {dac_left, dac_right}, 0);
  endtask

  task automatic t_format();
    setup(cfg(0, 0, 0, 1, 0, 0, 0, 0));
    wr(2'd2, 32'h0000_ABCD); tick();
    chk("R6 zero pad L", dac_left, 24'hABCD00);
    chk("R9 mono R", dac_right, 24'hABCD00);
    chk("R10 valid", dac_valid, 1);
    setup(cfg(0, 0, 1, 1, 0, 0, 0, 0));
    wr(2'd2, 32'h0000_8123); tick();
    chk("R7 msb repeat", dac_left, 24'h812381);
    setup(cfg(0, 1, 0, 1, 0, 0, 0, 0));
    wr(2'd2, 32'h1234_5678); tick();
    chk("R8 wide", dac_right, 24'h123456);
  endtask

  task automatic t_stereo();
    logic [31:0] d;
    setup(cfg(0, 0, 0, 0, 1, 0, 0, 3'd5));
    chk("R11 rate", rate_code, 3'd5);
    wr(2'd3, 32'd100);
    wr(2'd2, 32'h1111); wr(2'd2, 32'h2222);
    rd(2'd1, d); chk("R2 free", d[15:0], 30);
    tick();
    chk("R9 stereo L", dac_left, 24'h111100);
    chk("R9 stereo R", dac_right, 24'h222200);
    rd(2'd3, d); chk("R12 stereo count", d, 102);
    tick();
    chk("R10 hold last", {dac_left, dac_right}, {24'h111100, 24'h222200});
    rd(2'd1, d); chk("R10 underrun flag", d[17], 1);
    wr(2'd1, 32'h0002_0000);
    rd(2'd1, d); chk("R10 underrun clear", d[17], 0);
    wr(2'd2, 32'h3333); tick();
    rd(2'd1, d); chk("R10 partial frame kept", d[15:0], 31);
    chk("R10 partial held", dac_left, 24'h111100);
    setup(cfg(0, 0, 0, 1, 0, 0, 0, 0));
    wr(2'd2, 32'h4444); tick();
    rd(2'd3, d); chk("R12 mono count", d, 103);
    tick();
    chk("R10 zeros", {dac_left, dac_right}, 0);
  endtask

  task automatic t_overrun();
    logic [31:0] d;
    setup(cfg(0, 0, 0, 1, 0, 0, 0, 0));
    rd(2'd0, d); chk("R3 flush cleared", d[0], 0);
    for (int i = 0; i < 33; i++) wr(2'd2, 32'(i));
    rd(2'd1, d);
    chk("R2 full", d[15:0], 0);
    chk("R2 overrun", d[18], 1);
    wr(2'd1, 32'h0004_0000);
    rd(2'd1, d); chk("R2 overrun clear", d[18], 0);
    tick(); chk("R2 first kept", dac_left, 24'h000000);
    tick(); chk("R2 order", dac_left, 24'h000100);
    wr(2'd0, cfg(0, 0, 0, 1, 0, 0, 0, 0) | 1);
    rd(2'd0, d); chk("R3 flush visible", d[0], 1);
    idle(1);
    rd(2'd1, d); chk("R3 emptied", d[16:0], 17'h1_0020);
    rd(2'd0, d); chk("R3 self clear", d[0], 0);
  endtask

  task automatic t_dma();
    logic [31:0] d;
    setup(cfg(1, 0, 0, 0, 0, 2'd3, 6'd20, 0));
    idle(1); chk("R4 req on empty", dma_req, 1);
    for (int i = 0; i < 14; i++) wr(2'd2, 32'(i));
    idle(1); chk("R4 hold between (18)", dma_req, 1);
    for (int i = 0; i < 3; i++) wr(2'd2, 32'(i));
    idle(1); chk("R4 stop below 16", dma_req, 0);
    tick(); idle(1); chk("R4 hold low (17)", dma_req, 0);
    tick(); tick(); idle(1); chk("R4 restart above 20", dma_req, 1);
    rd(2'd1, d);
    wr(2'd0, cfg(0, 0, 0, 0, 0, 2'd3, 6'd20, 0));
    chk("R5 req dropped", dma_req, 0);
    rd(2'd1, bus_wdata); chk("R5 data kept", bus_wdata[15:0], d[15:0]);
  endtask

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(2); rst_n = 1'b1; idle(1);
    t_reset();
    t_format();
    t_stereo();
    t_overrun();
    t_dma();
    idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule